// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a single-request host port to an external asynchronous static RAM of 131,072 words by 16 bits. The host presents a 17-bit word address, a read/write flag, a two-bit lane mask and write data. The controller turns each accepted request into a complete memory cycle on the active-low chip-select, output-enable, write-enable and per-byte strobe pins. It drives the bidirectional data bus through separate in, out and output-enable signals.

Every timing window is set from nanosecond minimums and the clock period parameter. Each window is rounded up to whole cycles, with a floor of one. With the defaults (4 ns clock), a read keeps output enable low for 14 cycles, and the write-enable pulse lasts 14 cycles. The long byte-strobe figure applies because the address never moves during a pulse. The data bus is not driven until output enable has been high for 8 cycles.

All memory pins come straight from flops. Reads return the selected lanes in a register with a one-cycle valid pulse. Lanes that were masked off read as zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the chip select, output enable, write enable and both lane strobes are high, the data-bus enable is low, the host ready is high and the response valid is low.
- R2: A read holds chip select and output enable low and write enable high for exactly ACC_CYC cycles (14 by default). Response data and a single-cycle response valid appear 16 cycles after the accepting clock edge.
- R3: The lane mask uses bit 0 for data bits 7:0 (strobe bit 0) and bit 1 for bits 15:8 (strobe bit 1). In a read, only the lanes whose mask bit is 1 have their strobe low, and lanes whose mask bit is 0 return zero.
- R4: A write holds write enable low for exactly PULSE_CYC cycles (14 by default), with chip select low throughout. Only the lanes whose mask bit is 1 have their strobe low, and only those lanes of the stored word change.
- R5: The data-bus enable is high only during write cycles. It rises one cycle before write enable falls and falls one cycle after write enable rises, so it spans PULSE_CYC+2 cycles. It is never high while output enable is low.
- R6: The data-bus enable rises only after output enable has been high for at least TURN_CYC cycles (8 by default). A write accepted right after a read is therefore delayed by TURN_CYC-2 cycles.
- R7: The memory address changes only while write enable is high, and it stays at the accepted value until the next request is accepted.
- R8: Host ready is low from the accepting edge until the memory cycle ends, and requests and data presented meanwhile have no effect. A write with no turnaround wait completes 17 cycles after acceptance.
- R9: A write with mask 00 asserts no lane strobe and leaves the stored word unchanged.
- R10: Each window count is the nanosecond minimum divided by CLK_NS and rounded up, with a minimum of one. The write pulse takes the largest of the pulse-width, held-address strobe, data-setup and cycle-time windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller idle, request accepted when high with reqValid |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | Word address |
| reqMask | input | DATA_W/8 | Lane select, bit 0 for bits 7:0 |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | One-cycle read-data valid pulse |
| rspData | output | DATA_W | Read data, masked lanes zero |
| sramAddr | output | ADDR_W | Memory address |
| sramCeN | output | 1 | Chip select, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramBeN | output | DATA_W/8 | Lane strobes, active low, bit 0 lower byte |
| sramDqOut | output | DATA_W | Data driven to the memory |
| sramDqOe | output | 1 | Enable for the data-bus drivers |
| sramDqIn | input | DATA_W | Data read from the memory bus |

## Verification
For a read, the pins change one cycle after acceptance, and the response valid and data are due 16 cycles after the accepting edge. For a write, ready returns 17 cycles after acceptance when the bus is already quiet, and 23 cycles after it when the write follows a read back to back. The bench drives at falling edges and samples at every falling edge after acceptance. Over each operation it counts the cycles with write enable low, output enable low and the bus enable high, and compares latencies and counts with these figures. A bench memory model writes whichever lanes are strobed and returns filler on unstrobed lanes, so masking shows up in the read data.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_DONE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURNAROUND
  } ctrl_state_e;

  // strobes from the sequencer to the pin datapath
  typedef struct packed {
    logic load;      // latch host request fields
    logic ce;        // chip select wanted next cycle
    logic oe;        // output enable wanted next cycle
    logic we;        // write pulse wanted next cycle
    logic drvData;   // drive the data bus next cycle
    logic capture;   // sample the bus now, raise valid next cycle
  } lane_strobe_t;

  function automatic int cyclesFor(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int ACC_CYC   = 14,
  parameter int PULSE_CYC = 14,
  parameter int TURN_CYC  = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output lane_strobe_t strb
);

  localparam int CNT_W = $clog2(maxOf(ACC_CYC, PULSE_CYC) + 1);
  localparam int Q_W   = $clog2(TURN_CYC + 1);
  localparam logic [CNT_W-1:0] ACC_LOAD   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);
  localparam logic [Q_W-1:0]   QUIET_MAX  = Q_W'(TURN_CYC);
  localparam logic [Q_W-1:0]   QUIET_GO   = Q_W'(TURN_CYC - 1);

  ctrl_state_e      state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [Q_W-1:0]   quiet;
  logic             quietOk;
  logic             accept;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  // bus may be driven next cycle only if OE will then have been high TURN_CYC cycles
  assign quietOk  = (quiet >= QUIET_GO);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (!reqWrite) begin
            stateNext = ST_RD_ACCESS;
            cntNext   = ACC_LOAD;
          end else if (quietOk) begin
            stateNext = ST_WR_SETUP;
          end else begin
            stateNext = ST_TURNAROUND;
          end
        end
      end
      ST_RD_ACCESS: begin
        if (cnt == '0) stateNext = ST_RD_DONE;
        else           cntNext   = cnt - 1'b1;
      end
      ST_RD_DONE:    stateNext = ST_IDLE;
      ST_TURNAROUND: if (quietOk) stateNext = ST_WR_SETUP;
      ST_WR_SETUP: begin
        stateNext = ST_WR_PULSE;
        cntNext   = PULSE_LOAD;
      end
      ST_WR_PULSE: begin
        if (cnt == '0) stateNext = ST_WR_RECOVER;
        else           cntNext   = cnt - 1'b1;
      end
      ST_WR_RECOVER: stateNext = ST_IDLE;
      default:       stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.load    = accept;
    strb.ce      = (state == ST_RD_ACCESS) || (state == ST_WR_SETUP) || (state == ST_WR_PULSE);
    strb.oe      = (state == ST_RD_ACCESS);
    strb.we      = (state == ST_WR_PULSE);
    strb.drvData = (state == ST_WR_SETUP) || (state == ST_WR_PULSE) || (state == ST_WR_RECOVER);
    strb.capture = (state == ST_RD_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      quiet <= QUIET_MAX;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      if (strb.oe)                quiet <= '0;
      else if (quiet != QUIET_MAX) quiet <= quiet + 1'b1;
    end
  end

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lane_strobe_t      strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [LANES-1:0]  sramBeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int LANE_W = DATA_W / LANES;

  logic [LANES-1:0] maskQ;
  logic             laneAct;

  assign laneAct = strb.oe | strb.we;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sramAddr  <= '0;
      maskQ     <= '0;
      sramDqOut <= '0;
      sramCeN   <= 1'b1;
      sramOeN   <= 1'b1;
      sramWeN   <= 1'b1;
      sramDqOe  <= 1'b0;
      rspValid  <= 1'b0;
    end else begin
      if (strb.load) begin
        sramAddr  <= reqAddr;
        maskQ     <= reqMask;
        sramDqOut <= reqWdata;
      end
      sramCeN  <= ~strb.ce;
      sramOeN  <= ~strb.oe;
      sramWeN  <= ~strb.we;
      sramDqOe <= strb.drvData;
      rspValid <= strb.capture;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sramBeN[l]                  <= 1'b1;
        rspData[l*LANE_W +: LANE_W] <= '0;
      end else begin
        sramBeN[l] <= ~(laneAct & maskQ[l]);
        if (strb.capture)
          rspData[l*LANE_W +: LANE_W] <= maskQ[l] ? sramDqIn[l*LANE_W +: LANE_W] : '0;
      end
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 4,
  parameter int T_AA_NS   = 55,
  parameter int T_OE_NS   = 30,
  parameter int T_WP_NS   = 30,
  parameter int T_BW_NS   = 55,
  parameter int T_DW_NS   = 25,
  parameter int T_WC_NS   = 55,
  parameter int T_OHZ_NS  = 30
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W/8-1:0]   reqMask,
  input  logic [DATA_W-1:0]     reqWdata,
  output logic                  rspValid,
  output logic [DATA_W-1:0]     rspData,
  output logic [ADDR_W-1:0]     sramAddr,
  output logic                  sramCeN,
  output logic                  sramOeN,
  output logic                  sramWeN,
  output logic [DATA_W/8-1:0]   sramBeN,
  output logic [DATA_W-1:0]     sramDqOut,
  output logic                  sramDqOe,
  input  logic [DATA_W-1:0]     sramDqIn
);

  localparam int LANES     = DATA_W / 8;
  localparam int ACC_CYC   = maxOf(cyclesFor(T_AA_NS, CLK_NS), cyclesFor(T_OE_NS, CLK_NS));
  // setup+recover cycles surround the pulse, so the cycle-time term loses two
  localparam int PULSE_CYC = maxOf(maxOf(cyclesFor(T_WP_NS, CLK_NS), cyclesFor(T_BW_NS, CLK_NS)),
                                   maxOf(cyclesFor(T_DW_NS, CLK_NS), cyclesFor(T_WC_NS, CLK_NS) - 2));
  localparam int TURN_CYC  = cyclesFor(T_OHZ_NS, CLK_NS);

  lane_strobe_t strb;

  sram_lane_seq #(
    .ACC_CYC  (ACC_CYC),
    .PULSE_CYC(PULSE_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  sram_lane_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqMask  (reqMask),
    .reqWdata (reqWdata),
    .rspValid (rspValid),
    .rspData  (rspData),
    .sramAddr (sramAddr),
    .sramCeN  (sramCeN),
    .sramOeN  (sramOeN),
    .sramWeN  (sramWeN),
    .sramBeN  (sramBeN),
    .sramDqOut(sramDqOut),
    .sramDqOe (sramDqOe),
    .sramDqIn (sramDqIn)
  );

endmodule

// File: rtl/sram_lane_checker.sv
module sram_lane_checker #(
  parameter int ADDR_W   = 17,
  parameter int TURN_CYC = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramCeN,
  input logic              sramOeN,
  input logic              sramWeN,
  input logic              sramDqOe
);

  logic [15:0] oeHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              oeHighCnt <= 16'(TURN_CYC);
    else if (!sramOeN)      oeHighCnt <= '0;
    else if (oeHighCnt != 16'hFFFF) oeHighCnt <= oeHighCnt + 1'b1;
  end

  // R4: write pulse only inside chip select
  p_we_in_ce_r4: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> !sramCeN);

  // R2: output enable never overlaps write enable
  p_oe_not_we_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> sramWeN);

  // R2: response valid lasts a single cycle
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R5: no drive while the memory may be driving
  p_no_contend_r5: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> sramOeN);

  // R6: turnaround observed before the bus is driven
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramDqOe) |-> (oeHighCnt >= 16'(TURN_CYC)));

  // R7: address only moves while write enable is high
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sramAddr) |-> (sramWeN && $past(sramWeN)));

  // R8: read result is returned as the controller frees up
  p_ready_with_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady);

endmodule

bind sram_lane_ctrl sram_lane_checker #(
  .ADDR_W  (ADDR_W),
  .TURN_CYC(TURN_CYC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .sramAddr(sramAddr),
  .sramCeN (sramCeN),
  .sramOeN (sramOeN),
  .sramWeN (sramWeN),
  .sramDqOe(sramDqOe)
);

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [1:0]  reqMask = '0;
  logic [15:0] reqWdata = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic [16:0] sramAddr;
  logic        sramCeN, sramOeN, sramWeN, sramDqOe;
  logic [1:0]  sramBeN;
  logic [15:0] sramDqOut;
  logic [15:0] sramDqIn;

  int passCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqMask(reqMask), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .sramAddr(sramAddr),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN), .sramBeN(sramBeN),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  // small memory model, indexed by the low address byte
  logic [15:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

  always @(negedge clk) begin
    if (!sramCeN && !sramWeN && sramDqOe) begin
      if (!sramBeN[0]) mem[sramAddr[7:0]][7:0]  <= sramDqOut[7:0];
      if (!sramBeN[1]) mem[sramAddr[7:0]][15:8] <= sramDqOut[15:8];
    end
    if (rstN && sramDqOe && !sramOeN) begin
      failCnt++;
      $display("FAIL R5: bus driven while output enable low, actual dqOe=%0d oeN=%0d expected oeN=1", sramDqOe, sramOeN);
    end
  end

  assign sramDqIn = (!sramCeN && !sramOeN && sramWeN) ?
                    { sramBeN[1] ? 8'hEE : mem[sramAddr[7:0]][15:8],
                      sramBeN[0] ? 8'hEE : mem[sramAddr[7:0]][7:0] } : 16'hC3C3;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // start at a falling edge with the controller idle; return at the falling edge where ready is back
  task automatic doOp(input logic wr, input logic [16:0] a, input logic [1:0] m, input logic [15:0] d,
                      output int lat, output int weLow, output int oeLow, output int dqHigh,
                      output int addrBad, output int vldCnt, output logic [15:0] rd);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqMask = m; reqWdata = d;
    @(posedge clk);
    lat = 0; weLow = 0; oeLow = 0; dqHigh = 0; addrBad = 0; vldCnt = 0; rd = '0;
    do begin
      @(negedge clk);
      if (lat == 0) reqValid = 1'b0;
      lat++;
      if (!sramWeN) weLow++;
      if (!sramOeN) oeLow++;
      if (sramDqOe) dqHigh++;
      if (sramAddr != a) addrBad++;
      if (rspValid) begin vldCnt++; rd = rspData; end
    end while (!reqReady && lat < 1000);
  endtask

  typedef struct packed {
    logic        wr;
    logic [16:0] addr;
    logic [1:0]  mask;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 17'h00012, 2'b11, 16'hA55A},
    '{1'b0, 17'h00012, 2'b11, 16'hA55A},
    '{1'b1, 17'h00012, 2'b01, 16'h1234},
    '{1'b0, 17'h00012, 2'b11, 16'hA534},
    '{1'b1, 17'h00012, 2'b10, 16'h77FF},
    '{1'b0, 17'h00012, 2'b10, 16'h7700},
    '{1'b0, 17'h00012, 2'b01, 16'h0034},
    '{1'b1, 17'h1FF40, 2'b11, 16'hBEEF},
    '{1'b0, 17'h1FF40, 2'b11, 16'hBEEF},
    '{1'b1, 17'h1FF40, 2'b00, 16'h0000},
    '{1'b0, 17'h1FF40, 2'b11, 16'hBEEF},
    '{1'b0, 17'h00012, 2'b00, 16'h0000}
  };

  initial begin
    repeat (50000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    int lat, weLow, oeLow, dqHigh, addrBad, vldCnt;
    logic [15:0] rd;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(sramCeN && sramOeN && sramWeN && sramBeN == 2'b11, "R1 strobes in reset",
          {sramCeN, sramOeN, sramWeN, sramBeN}, 5'h1F);
    check(!sramDqOe && reqReady && !rspValid, "R1 bus/ready/valid in reset",
          {sramDqOe, reqReady, rspValid}, 3'b010);
    rstN = 1'b1;
    repeat (12) @(negedge clk);
    check(sramCeN && sramOeN && sramWeN && sramBeN == 2'b11 && !sramDqOe && reqReady && !rspValid,
          "R1 idle after reset", {sramCeN, sramOeN, sramWeN, sramBeN, sramDqOe, reqReady, rspValid}, 8'hFA);

    // vector table
    for (int v = 0; v < NV; v++) begin
      doOp(VECS[v].wr, VECS[v].addr, VECS[v].mask, VECS[v].data, lat, weLow, oeLow, dqHigh, addrBad, vldCnt, rd);
      check(addrBad == 0, "R7 address held during op", addrBad, 0);
      if (VECS[v].wr) begin
        check(oeLow == 0 && vldCnt == 0, "R5 no read activity in write", {oeLow[15:0], vldCnt[15:0]}, 0);
        check(weLow == 14, "R4 write pulse length", weLow, 14);
      end else begin
        check(lat == 16 && vldCnt == 1, "R2 read latency and single valid", {lat[15:0], vldCnt[15:0]}, {16'd16, 16'd1});
        check(oeLow == 14 && weLow == 0 && dqHigh == 0, "R2 read window", {oeLow[7:0], weLow[7:0], dqHigh[7:0]}, {8'd14, 8'd0, 8'd0});
        check(rd == VECS[v].data, "R3 read data with lane masking", rd, VECS[v].data);
      end
      repeat (10) @(negedge clk);
    end

    // R8 R10 write from quiet bus: latency, pulse and bus enable spans
    doOp(1'b1, 17'h00055, 2'b11, 16'h5AA5, lat, weLow, oeLow, dqHigh, addrBad, vldCnt, rd);
    check(lat == 17, "R8 write latency from quiet bus", lat, 17);
    check(weLow == 14, "R10 rounded pulse 55ns/4ns", weLow, 14);
    check(dqHigh == 16, "R5 bus enable span", dqHigh, 16);

    // R6 write immediately after read waits for turnaround
    doOp(1'b0, 17'h00055, 2'b11, 16'h0, lat, weLow, oeLow, dqHigh, addrBad, vldCnt, rd);
    check(rd == 16'h5AA5, "R4 full word written", rd, 16'h5AA5);
    doOp(1'b1, 17'h00056, 2'b01, 16'h0F0F, lat, weLow, oeLow, dqHigh, addrBad, vldCnt, rd);
    check(lat == 23, "R6 write after read delayed by turnaround", lat, 23);
    check(weLow == 14 && dqHigh == 16, "R6 pulse intact after turnaround", {weLow[15:0], dqHigh[15:0]}, {16'd14, 16'd16});

    // R3 strobe pattern observed during a lower-only read
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 17'h00056; reqMask = 2'b01;
    @(posedge clk);
    @(negedge clk); reqValid = 1'b0;
    @(negedge clk);
    check(sramBeN == 2'b10 && !sramCeN && !sramOeN && sramWeN, "R3 lower strobe only in read",
          {sramBeN, sramCeN, sramOeN, sramWeN}, 5'b10001);
    while (!reqReady) @(negedge clk);
    check(rspData == 16'h000F, "R3 lower lane read", rspData, 16'h000F);
    repeat (10) @(negedge clk);

    // R8 busy: changed request fields and held valid have no effect until ready
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 17'h00070; reqMask = 2'b11; reqWdata = 16'h1111;
    @(posedge clk);
    @(negedge clk);
    reqAddr = 17'h00071; reqWdata = 16'h2222;
    repeat (5) @(negedge clk);
    check(!reqReady && sramAddr == 17'h00070, "R8 busy ignores new request", {reqReady, sramAddr}, {1'b0, 17'h00070});
    check(sramDqOut == 16'h1111, "R8 busy keeps accepted data", sramDqOut, 16'h1111);
    reqValid = 1'b0;
    while (!reqReady) @(negedge clk);
    repeat (10) @(negedge clk);
    doOp(1'b0, 17'h00071, 2'b11, 16'h0, lat, weLow, oeLow, dqHigh, addrBad, vldCnt, rd);
    check(rd == 16'h0000, "R8 ignored request not written", rd, 16'h0000);
    repeat (10) @(negedge clk);
    doOp(1'b0, 17'h00070, 2'b11, 16'h0, lat, weLow, oeLow, dqHigh, addrBad, vldCnt, rd);
    check(rd == 16'h1111, "R8 accepted request written", rd, 16'h1111);
    repeat (10) @(negedge clk);

    // R9 empty-mask write: no strobes at all
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 17'h00070; reqMask = 2'b00; reqWdata = 16'hFFFF;
    @(posedge clk);
    @(negedge clk); reqValid = 1'b0;
    begin
      int strobeSeen = 0;
      while (!reqReady) begin
        if (sramBeN != 2'b11) strobeSeen++;
        @(negedge clk);
      end
      check(strobeSeen == 0, "R9 no lane strobe for empty mask", strobeSeen, 0);
    end
    repeat (10) @(negedge clk);
    doOp(1'b0, 17'h00070, 2'b11, 16'h0, lat, weLow, oeLow, dqHigh, addrBad, vldCnt, rd);
    check(rd == 16'h1111, "R9 word unchanged after empty mask", rd, 16'h1111);

    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

endmodule